// File: doc/BRIEF.md
# Per-Flow Cell Routing Lookup

This block sits at the ingress of one port of a four-port cell switch. For every arriving fixed-size cell it reads the path identifier and the channel identifier from the header word. From these it decides which of the four output ports receive the cell. The answer is a four-bit destination bitmap with one bit per output port. A bitmap with several bits set tells the fabric to copy the cell to every port it names, so multicast needs no separate mechanism.

Two on-chip tables hold the routes. The aggregate table is indexed by the path identifier and carries one route for a whole bundle of flows. The per-flow table is indexed by the channel identifier and can single out an individual flow, which then takes precedence over its bundle's route. Every entry has a valid bit. A cell that finds no valid entry is sent to a default destination set held in a register. All three are written through one address/data/write-enable port. The lookup is fully pipelined: one header per cycle is accepted, and each result appears a fixed two cycles later, together with a tag that identifies the cell.

Top module: `cell_route_lookup`

## Requirements
- R1: After reset, out_vld and out_map are low, every entry of both tables is invalid, and the default destination is 4'b0001, so the first cells go to port 0 only.
- R2: A header presented with hdr_vld high in cycle t produces out_vld high in cycle t+2 with out_tag equal to hdr_tag; in every cycle with no result, out_vld and out_map are zero.
- R3: When hdr_vci is below 1024 and the per-flow entry at that index is valid, out_map is that entry's bitmap, whatever the aggregate table holds.
- R4: When R3 does not apply, hdr_vpi is below 1024 and the aggregate entry at that index is valid, out_map is that aggregate entry's bitmap.
- R5: When neither table supplies a valid entry, out_map is the default destination register.
- R6: Identifiers at or above 1024 never consult their table: a channel identifier of 1024 or more falls through to the aggregate table, and a path identifier of 1024 or more falls through to the default.
- R7: Writes use wr_tgt = 0 for the aggregate table, 1 for the per-flow table, 2 for the default register (loaded from wr_map), and 3 for nothing; wr_valid is stored as the entry's valid bit, so a write with wr_valid low removes the entry.
- R8: A write in the same cycle as a header does not affect that header's result (the old entry or old default is used); it does affect the next header.
- R9: out_map carries the selected bitmap unchanged, including bitmaps with several bits set and an all-zero bitmap from a valid entry, which produces out_vld high with no destination.
- R10: Headers on consecutive cycles are resolved independently, each against the table state at its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_vld | input | 1 | Header word with identifiers is present |
| hdr_vpi | input | VPI_W (12) | Path identifier |
| hdr_vci | input | VCI_W (16) | Channel identifier |
| hdr_tag | input | TAG_W (8) | Cell handle carried alongside the lookup |
| wr_en | input | 1 | Write strobe |
| wr_tgt | input | 2 | Write target: 0 aggregate, 1 per-flow, 2 default, 3 none |
| wr_addr | input | TBL_AW (10) | Entry index |
| wr_map | input | 4 | Destination bitmap to store |
| wr_valid | input | 1 | Valid bit to store with the entry |
| out_vld | output | 1 | Routing result present |
| out_map | output | 4 | Destination bitmap, bit n for output port n |
| out_tag | output | TAG_W (8) | Tag of the routed cell |

## Verification
The bench goes after the priority order. A per-flow hit must mask an aggregate hit, and a design that checked the tables the other way round would send overridden flows along their bundle's route. Identifiers at 1023 and 1024 are probed on both tables: a design that truncated the index instead of range-checking it would alias channel 1024 onto entry 0 and route it wrongly. Writes that land in the same cycle as a lookup of the same entry, or of the default register, must leave that lookup with the old value; a design that forwarded the write would show the new bitmap one cell early. Target code 3, invalidating writes and valid all-zero entries are checked, because a design that misdecoded them would corrupt a table or treat a deliberate drop as a miss.

// File: rtl/cell_route_pkg.sv
package cell_route_pkg;
    localparam int PORTS = 4;

    typedef logic [PORTS-1:0] portmap_t;

    typedef enum logic [1:0] {
        TGT_PATH = 2'd0,
        TGT_FLOW = 2'd1,
        TGT_DFLT = 2'd2,
        TGT_NONE = 2'd3
    } wr_target_e;
endpackage

// File: rtl/vc_route_table.sv
module vc_route_table
    import cell_route_pkg::*;
#(
    parameter int AW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  portmap_t      wr_map,
    input  logic          wr_valid,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output portmap_t      rd_map,
    output logic          rd_hit
);
    localparam int DEPTH = 1 << AW;

    portmap_t         map_mem [DEPTH];
    logic [DEPTH-1:0] vld_q;

    // bitmap storage: no reset, guarded by the valid bits
    always_ff @(posedge clk) begin
        if (wr_en) begin
            map_mem[wr_addr] <= wr_map;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_addr] <= wr_valid;
        end
    end

    // synchronous read sees the contents before any write at the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_map <= '0;
            rd_hit <= 1'b0;
        end else if (rd_en) begin
            rd_map <= map_mem[rd_addr];
            rd_hit <= vld_q[rd_addr];
        end
    end
endmodule

// File: rtl/route_select.sv
module route_select
    import cell_route_pkg::*;
(
    input  logic     flow_use,
    input  portmap_t flow_map,
    input  logic     path_use,
    input  portmap_t path_map,
    input  portmap_t dflt_map,
    output portmap_t sel_map
);
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        always_comb begin
            if (flow_use) begin
                sel_map[p] = flow_map[p];
            end else if (path_use) begin
                sel_map[p] = path_map[p];
            end else begin
                sel_map[p] = dflt_map[p];
            end
        end
    end
endmodule

// File: rtl/cell_route_lookup.sv
module cell_route_lookup
    import cell_route_pkg::*;
#(
    parameter int                   VPI_W    = 12,
    parameter int                   VCI_W    = 16,
    parameter int                   TBL_AW   = 10,
    parameter int                   TAG_W    = 8,
    parameter logic [PORTS-1:0]     DFLT_RST = 4'b0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hdr_vld,
    input  logic [VPI_W-1:0]  hdr_vpi,
    input  logic [VCI_W-1:0]  hdr_vci,
    input  logic [TAG_W-1:0]  hdr_tag,
    input  logic              wr_en,
    input  logic [1:0]        wr_tgt,
    input  logic [TBL_AW-1:0] wr_addr,
    input  logic [PORTS-1:0]  wr_map,
    input  logic              wr_valid,
    output logic              out_vld,
    output logic [PORTS-1:0]  out_map,
    output logic [TAG_W-1:0]  out_tag
);
    logic vpi_in, vci_in;

    // identifiers wider than the table index are range-checked
    if (VPI_W > TBL_AW) begin : g_vpi_rng
        assign vpi_in = ~|hdr_vpi[VPI_W-1:TBL_AW];
    end else begin : g_vpi_all
        assign vpi_in = 1'b1;
    end

    if (VCI_W > TBL_AW) begin : g_vci_rng
        assign vci_in = ~|hdr_vci[VCI_W-1:TBL_AW];
    end else begin : g_vci_all
        assign vci_in = 1'b1;
    end

    logic path_we, flow_we, dflt_we;
    assign path_we = wr_en && (wr_tgt == TGT_PATH);
    assign flow_we = wr_en && (wr_tgt == TGT_FLOW);
    assign dflt_we = wr_en && (wr_tgt == TGT_DFLT);

    portmap_t dflt_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dflt_q <= DFLT_RST;
        end else if (dflt_we) begin
            dflt_q <= wr_map;
        end
    end

    portmap_t path_map, flow_map;
    logic     path_hit, flow_hit;

    vc_route_table #(.AW(TBL_AW)) i_path_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (path_we),
        .wr_addr  (wr_addr),
        .wr_map   (wr_map),
        .wr_valid (wr_valid),
        .rd_en    (hdr_vld),
        .rd_addr  (hdr_vpi[TBL_AW-1:0]),
        .rd_map   (path_map),
        .rd_hit   (path_hit)
    );

    vc_route_table #(.AW(TBL_AW)) i_flow_tbl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (flow_we),
        .wr_addr  (wr_addr),
        .wr_map   (wr_map),
        .wr_valid (wr_valid),
        .rd_en    (hdr_vld),
        .rd_addr  (hdr_vci[TBL_AW-1:0]),
        .rd_map   (flow_map),
        .rd_hit   (flow_hit)
    );

    // stage one: header context alongside the table reads
    logic             s1_vld, s1_path_in, s1_flow_in;
    logic [TAG_W-1:0] s1_tag;
    portmap_t         s1_dflt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_vld     <= 1'b0;
            s1_path_in <= 1'b0;
            s1_flow_in <= 1'b0;
            s1_tag     <= '0;
            s1_dflt    <= '0;
        end else begin
            s1_vld <= hdr_vld;
            if (hdr_vld) begin
                s1_path_in <= vpi_in;
                s1_flow_in <= vci_in;
                s1_tag     <= hdr_tag;
                s1_dflt    <= dflt_q;
            end
        end
    end

    logic     s1_flow_use, s1_path_use;
    portmap_t sel_map;
    assign s1_flow_use = s1_flow_in && flow_hit;
    assign s1_path_use = s1_path_in && path_hit;

    route_select i_sel (
        .flow_use (s1_flow_use),
        .flow_map (flow_map),
        .path_use (s1_path_use),
        .path_map (path_map),
        .dflt_map (s1_dflt),
        .sel_map  (sel_map)
    );

    // stage two: registered result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_map <= '0;
            out_tag <= '0;
        end else begin
            out_vld <= s1_vld;
            out_map <= s1_vld ? sel_map : '0;
            out_tag <= s1_vld ? s1_tag : '0;
        end
    end
endmodule

// File: rtl/cell_route_chk.sv
module cell_route_chk
    import cell_route_pkg::*;
#(
    parameter int TAG_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             hdr_vld,
    input logic [TAG_W-1:0] hdr_tag,
    input logic             out_vld,
    input portmap_t         out_map,
    input logic [TAG_W-1:0] out_tag,
    input logic             s1_vld,
    input logic             s1_flow_use,
    input logic             s1_path_use,
    input portmap_t         flow_map,
    input portmap_t         path_map,
    input portmap_t         s1_dflt
);
    logic [1:0] seen;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen <= '0;
        end else if (seen != 2'd3) begin
            seen <= seen + 2'd1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (seen == 2'd0) |-> (!out_vld && out_map == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2) |-> (out_vld == $past(hdr_vld, 2)));

    assert_tag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (seen >= 2'd2 && out_vld) |-> (out_tag == $past(hdr_tag, 2)));

    assert_idle_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_map == '0));

    assert_flow_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && s1_flow_use) |=> (out_map == $past(flow_map)));

    assert_path_fallback_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_flow_use && s1_path_use) |=> (out_map == $past(path_map)));

    assert_default_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_vld && !s1_flow_use && !s1_path_use) |=> (out_map == $past(s1_dflt)));
endmodule

bind cell_route_lookup cell_route_chk #(.TAG_W(TAG_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_vld     (hdr_vld),
    .hdr_tag     (hdr_tag),
    .out_vld     (out_vld),
    .out_map     (out_map),
    .out_tag     (out_tag),
    .s1_vld      (s1_vld),
    .s1_flow_use (s1_flow_use),
    .s1_path_use (s1_path_use),
    .flow_map    (flow_map),
    .path_map    (path_map),
    .s1_dflt     (s1_dflt)
);

// File: tb/test_cell_route_lookup.sv
module test_cell_route_lookup;
    localparam int VPI_W  = 12;
    localparam int VCI_W  = 16;
    localparam int TBL_AW = 10;
    localparam int TAG_W  = 8;
    localparam int DEPTH  = 1 << TBL_AW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hdr_vld = 1'b0;
    logic [VPI_W-1:0]  hdr_vpi = '0;
    logic [VCI_W-1:0]  hdr_vci = '0;
    logic [TAG_W-1:0]  hdr_tag = '0;
    logic              wr_en = 1'b0;
    logic [1:0]        wr_tgt = '0;
    logic [TBL_AW-1:0] wr_addr = '0;
    logic [3:0]        wr_map = '0;
    logic              wr_valid = 1'b0;
    logic              out_vld;
    logic [3:0]        out_map;
    logic [TAG_W-1:0]  out_tag;

    always #2 clk = ~clk;   // 250 MHz

    cell_route_lookup i_cell_route_lookup (
        .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_vpi(hdr_vpi),
        .hdr_vci(hdr_vci), .hdr_tag(hdr_tag), .wr_en(wr_en), .wr_tgt(wr_tgt),
        .wr_addr(wr_addr), .wr_map(wr_map), .wr_valid(wr_valid),
        .out_vld(out_vld), .out_map(out_map), .out_tag(out_tag)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // reference model of the tables
    logic [3:0] m_pmap [DEPTH];
    bit         m_pv   [DEPTH];
    logic [3:0] m_fmap [DEPTH];
    bit         m_fv   [DEPTH];
    logic [3:0] m_dflt;

    // expected results in flight: e0 driven last cycle, e1 two cycles ago
    bit               e0_v, e1_v;
    logic [3:0]       e0_map, e1_map;
    logic [TAG_W-1:0] e0_tag, e1_tag;
    string            e0_r, e1_r;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] ref_route(input logic [VPI_W-1:0] vpi,
                                             input logic [VCI_W-1:0] vci,
                                             output string rule);
        if (vci < DEPTH && m_fv[vci[TBL_AW-1:0]]) begin
            rule = "R3";
            return m_fmap[vci[TBL_AW-1:0]];
        end else if (vpi < DEPTH && m_pv[vpi[TBL_AW-1:0]]) begin
            rule = "R4";
            return m_pmap[vpi[TBL_AW-1:0]];
        end
        rule = "R5";
        return m_dflt;
    endfunction

    // called at a falling edge: check, predict, update model, drive
    task automatic step(input bit hv, input int vpi, input int vci, input int tag,
                        input bit we, input int tgt, input int addr, input int map,
                        input bit val, input string note);
        string rule;
        logic [3:0] em;
        if (e1_v) begin
            check(out_vld == 1'b1, {"R2 ", e1_r}, 32'(out_vld), 32'd1);
            check(out_map == e1_map, e1_r, 32'(out_map), 32'(e1_map));
            check(out_tag == e1_tag, {"R2 ", e1_r}, 32'(out_tag), 32'(e1_tag));
        end else begin
            check(out_vld == 1'b0 && out_map == 4'd0, "R2 idle", 32'({out_vld, out_map}), 32'd0);
        end
        e1_v = e0_v; e1_map = e0_map; e1_tag = e0_tag; e1_r = e0_r;
        e0_v = hv;
        if (hv) begin
            em = ref_route(VPI_W'(vpi), VCI_W'(vci), rule);
            e0_map = em; e0_tag = TAG_W'(tag); e0_r = {note, " ", rule};
        end
        if (we) begin
            case (tgt)
                0: begin m_pmap[addr] = 4'(map); m_pv[addr] = val; end
                1: begin m_fmap[addr] = 4'(map); m_fv[addr] = val; end
                2: m_dflt = 4'(map);
                default: ;
            endcase
        end
        hdr_vld = hv; hdr_vpi = VPI_W'(vpi); hdr_vci = VCI_W'(vci); hdr_tag = TAG_W'(tag);
        wr_en = we; wr_tgt = 2'(tgt); wr_addr = TBL_AW'(addr); wr_map = 4'(map);
        wr_valid = val;
        @(negedge clk);
    endtask

    task automatic hdr(input int vpi, input int vci, input int tag, input string note);
        step(1'b1, vpi, vci, tag, 1'b0, 0, 0, 0, 1'b0, note);
    endtask

    task automatic wr(input int tgt, input int addr, input int map, input bit val,
                      input string note);
        step(1'b0, 0, 0, 0, 1'b1, tgt, addr, map, val, note);
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        for (int i = 0; i < DEPTH; i++) begin
            m_pv[i] = 1'b0; m_fv[i] = 1'b0; m_pmap[i] = '0; m_fmap[i] = '0;
        end
        m_dflt = 4'b0001;
        e0_v = 1'b0; e1_v = 1'b0;
        repeat (3) @(negedge clk);
        check(out_vld == 1'b0 && out_map == 4'd0, "R1 reset", 32'({out_vld, out_map}), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        hdr(3, 7, 8'h11, "R1 empty tables");
        // default write in same cycle as a header: old default applies
        step(1'b1, 3, 7, 8'h12, 1'b1, 2, 0, 4'b1010, 1'b1, "R8 default");
        hdr(3, 7, 8'h13, "R7 default");
        wr(0, 3, 4'b0110, 1'b1, "R7");
        hdr(3, 2000, 8'h14, "R6 vci high");
        wr(1, 7, 4'b1001, 1'b1, "R7");
        hdr(3, 7, 8'h15, "R3 priority");
        step(1'b1, 3, 7, 8'h16, 1'b1, 1, 7, 4'b1111, 1'b1, "R8 collide");
        hdr(3, 7, 8'h17, "R9 multicast");
        wr(1, 1023, 4'b0100, 1'b1, "R7");
        wr(1, 0, 4'b1000, 1'b1, "R7");
        hdr(3, 1023, 8'h18, "R6 edge 1023");
        hdr(3, 1024, 8'h19, "R6 vci 1024");
        wr(0, 0, 4'b0011, 1'b1, "R7");
        hdr(1024, 5000, 8'h1a, "R6 vpi 1024");
        hdr(1023, 5000, 8'h1b, "R6 vpi 1023");
        wr(3, 3, 4'b0000, 1'b1, "R7 target 3");
        hdr(3, 2000, 8'h1c, "R7 target 3");
        wr(1, 7, 4'b1111, 1'b0, "R7 invalidate");
        hdr(3, 7, 8'h1d, "R7 invalidate");
        wr(1, 9, 4'b0000, 1'b1, "R9");
        hdr(3, 9, 8'h1e, "R9 zero map");

        // R10: random back-to-back traffic mixed with writes
        for (int n = 0; n < 4000; n++) begin
            int r, vpi, vci, addr;
            r = int'($urandom % 10);
            vpi = (r < 7) ? int'($urandom % 16) : (r < 9 ? int'($urandom % DEPTH)
                                                         : int'($urandom % (1 << VPI_W)));
            r = int'($urandom % 10);
            vci = (r < 6) ? int'($urandom % 16) : (r < 8 ? int'($urandom % DEPTH)
                                                         : int'($urandom % (1 << VCI_W)));
            addr = ($urandom % 8 == 0) ? int'($urandom % DEPTH) : int'($urandom % 16);
            step(($urandom % 5) != 0, vpi, vci, int'($urandom % 256),
                 ($urandom % 5) < 2, int'($urandom % 4), addr, int'($urandom % 16),
                 ($urandom % 4) != 0, "R10");
        end
        repeat (3) step(1'b0, 0, 0, 0, 1'b0, 0, 0, 0, 1'b0, "R2 drain");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule